// File: doc/BRIEF.md
# Calendar Alarm with Repeat Modes

This block watches a running calendar clock held in BCD and raises an alarm when the clock reaches a programmed moment. Five alarm registers hold a target second, minute, hour, day-of-month and month. Five repeat bits, spread across the upper bits of those registers, choose which of these fields take part in the comparison. The choices run from a match every second to a match once a year. The comparison is made only on a once-per-second strobe, which is the same strobe that advances the clock, so each matching second gives exactly one alarm event.

An alarm event sets an alarm flag that software can read in a flags register. If the alarm interrupt is enabled, the event also asserts an enable for an active-low open-drain interrupt pin. Clearing takes two reads of the flags register. The first read releases the pin. The next read clears the flag. When the system runs from its backup battery, the pin is driven only if a second enable, for backup operation, is also set. Reset stands for power-up. It clears every register, so an alarm seen right after power-up sets only the flag.

Top module: `cal_alarm`

## Requirements
- R1: Alarm registers sit at byte addresses 2 (second), 3 (minute), 4 (hour), 5 (date) and 6 (month), and each reads back the full byte last written. The flags register at address 0 returns the alarm flag at bit 6 and zeros in every other bit. Addresses 1 and 7 to 15 read as zero.
- R2: Bit 7 of the month register enables the interrupt and bit 6 enables it in backup mode. The repeat bits, from finest to coarsest, are bit 7 of registers 2, 3, 4 and 5 and bit 6 of register 5.
- R3: The repeat code is written from coarsest to finest bit. Code 11111 compares no field. Code 11110 compares the second. Code 11100 compares second and minute. Code 11000 adds the hour. Code 10000 adds the date. Code 00000 compares all five fields.
- R4: Any other repeat code behaves as code 11111: every strobe matches.
- R5: The flag is set only in a cycle with the strobe, and only when every compared field is equal. Field widths are 7 bits for second and minute, 6 bits for hour and date, and 5 bits for month. Register bits outside a field and outside R2 take no part.
- R6: With the interrupt enabled, a match sets the flag to 1 and sets irq_n_oe to 1 from the clock edge that samples the strobe.
- R7: With the interrupt enable at 0, a match sets the flag and irq_n_oe stays 0.
- R8: A flags read while the interrupt is pending releases irq_n_oe and keeps the flag. A flags read with no pending interrupt clears the flag.
- R9: While on_battery is 1, irq_n_oe is 1 only if both enables are 1. A match still sets the flag.
- R10: Reset clears all alarm registers, the flag and the interrupt.
- R11: An alarm date of 00 with the four finest repeat bits at 0 never sets the flag for a valid calendar date.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset (power-up) |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| cur_sec | input | 7 | Current second, BCD |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD, 24-hour |
| cur_date | input | 6 | Current day of month, BCD |
| cur_mon | input | 5 | Current month, BCD |
| on_battery | input | 1 | System is in battery backup mode |
| bus_addr | input | 4 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe (a flags read has side effects) |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| irq_n_oe | output | 1 | 1 pulls the interrupt pin low |

## Verification
The properties on flag clearing assume that a flags read never falls in the same cycle as the strobe. They also assume the strobe is a single-cycle pulse and the time inputs hold steady BCD values around it. The stimulus keeps to this: reads, writes and strobes always go in separate cycles, and the time inputs change only between strobes. The properties on the interrupt pin hold for any input, so the backup and enable changes are driven freely between events.

// File: rtl/cal_alarm_pkg.sv
// Shared constants and helpers for the calendar alarm.
// Assumes BCD time fields no wider than FIELD_W bits.
package cal_alarm_pkg;
    localparam int DATA_W    = 8;
    localparam int ADDR_W    = 4;
    localparam int NFIELD    = 5;
    localparam int FIELD_W   = 7;
    localparam int ALM_BASE  = 2;
    localparam int FLAG_ADDR = 0;
    localparam int AF_BIT    = 6;
    // field indices, finest first; field i lives at ALM_BASE+i
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_DATE = 3;
    localparam int F_MON  = 4;

    typedef logic [FIELD_W-1:0] field_t;

    // Bits that carry BCD data for a given field
    function automatic field_t field_mask(input int idx);
        case (idx)
            F_HOUR, F_DATE: return field_t'(6'h3F);
            F_MON:          return field_t'(5'h1F);
            default:        return field_t'(7'h7F);
        endcase
    endfunction
endpackage

// File: rtl/cal_alarm_regs.sv
// Alarm register file: stores the five alarm bytes and pulls the fields,
// repeat bits and enables out of them. Read data is combinational.
// Assumes one access per cycle; the flags byte is supplied by the flag unit.
module cal_alarm_regs
    import cal_alarm_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [ADDR_W-1:0]          addr,
    input  logic [DATA_W-1:0]          wdata,
    input  logic                       af,
    output logic [DATA_W-1:0]          rdata,
    output logic [NF-1:0][FIELD_W-1:0] alm_field,
    output logic [NF-1:0]              rpt,
    output logic                       afe,
    output logic                       abe
);
    logic [NF-1:0][DATA_W-1:0] store;

    // Capture writes to the alarm byte selected by the address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            store <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NF; i++) begin
                if (addr == ADDR_W'(ALM_BASE + i)) store[i] <= wdata;
            end
        end
    end

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_field
            assign alm_field[g] = store[g][FIELD_W-1:0] & field_mask(g);
            if (g < NF - 1) begin : g_rpt_top
                assign rpt[g] = store[g][DATA_W-1];
            end else begin : g_rpt_last
                assign rpt[g] = store[F_DATE][DATA_W-2];
            end
        end
    endgenerate

    assign afe = store[F_MON][DATA_W-1];
    assign abe = store[F_MON][DATA_W-2];

    // Read multiplexer over flags and alarm bytes
    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(FLAG_ADDR)) rdata[AF_BIT] = af;
        for (int i = 0; i < NF; i++) begin
            if (addr == ADDR_W'(ALM_BASE + i)) rdata = store[i];
        end
    end
endmodule

// File: rtl/cal_alarm_match.sv
// Repeat-mode decode and field comparison. A valid repeat code is a run of
// ones from the coarsest bit down; any other code compares nothing.
// Assumes inputs already masked to their field widths.
module cal_alarm_match
    import cal_alarm_pkg::*;
#(
    parameter int NF = NFIELD
) (
    input  logic [NF-1:0][FIELD_W-1:0] alm_field,
    input  logic [NF-1:0][FIELD_W-1:0] now_field,
    input  logic [NF-1:0]              rpt,
    output logic                       hit
);
    logic [NF:0]   inv_code;
    logic          code_ok;
    logic [NF-1:0] cmp_en;
    logic [NF-1:0] eq;

    // Valid when the inverted code is a run of ones from bit 0
    always_comb begin
        inv_code = {1'b0, ~rpt};
        code_ok  = ((inv_code & (inv_code + 1'b1)) == '0);
        cmp_en   = code_ok ? ~rpt : '0;
    end

    genvar g;
    generate
        for (g = 0; g < NF; g++) begin : g_cmp
            assign eq[g] = (alm_field[g] == now_field[g]);
        end
    endgenerate

    assign hit = &(eq | ~cmp_en);
endmodule

// File: rtl/cal_alarm_flag.sv
// Alarm flag and interrupt state. A strobed match sets the flag and, when
// allowed, the pending interrupt; flags reads clear in two steps.
// Assumes a strobed match wins over a flags read in the same cycle.
module cal_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic hit,
    input  logic afe,
    input  logic abe,
    input  logic backup,
    input  logic flag_rd,
    output logic af,
    output logic irq_pend,
    output logic irq_n_oe
);
    logic irq_ok;

    // Interrupt allowed by enables and supply state
    assign irq_ok = afe & (~backup | abe);

    // Set on strobed match; release interrupt, then flag, on reads
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            af       <= 1'b0;
            irq_pend <= 1'b0;
        end else if (tick && hit) begin
            af <= 1'b1;
            if (irq_ok) irq_pend <= 1'b1;
        end else if (flag_rd) begin
            if (irq_pend) irq_pend <= 1'b0;
            else          af       <= 1'b0;
        end
    end

    assign irq_n_oe = irq_pend & irq_ok;
endmodule

// File: rtl/cal_alarm.sv
// Calendar alarm top: packs the time inputs into fields and ties the
// register file, comparator and flag unit together.
// Assumes sec_tick is a one-cycle pulse once per second.
module cal_alarm
    import cal_alarm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic [6:0]        cur_sec,
    input  logic [6:0]        cur_min,
    input  logic [5:0]        cur_hour,
    input  logic [5:0]        cur_date,
    input  logic [4:0]        cur_mon,
    input  logic              on_battery,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq_n_oe
);
    logic [NFIELD-1:0][FIELD_W-1:0] alm_field;
    logic [NFIELD-1:0][FIELD_W-1:0] now_field;
    logic [NFIELD-1:0]              rpt;
    logic afe, abe, hit, af, irq_pend, flag_rd;

    // Current time as zero-extended fields, finest first
    always_comb begin
        now_field[F_SEC]  = field_t'(cur_sec);
        now_field[F_MIN]  = field_t'(cur_min);
        now_field[F_HOUR] = field_t'(cur_hour);
        now_field[F_DATE] = field_t'(cur_date);
        now_field[F_MON]  = field_t'(cur_mon);
    end

    assign flag_rd = bus_rd && (bus_addr == ADDR_W'(FLAG_ADDR));

    cal_alarm_regs #(.NF(NFIELD)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .af(af), .rdata(bus_rdata),
        .alm_field(alm_field), .rpt(rpt), .afe(afe), .abe(abe)
    );

    cal_alarm_match #(.NF(NFIELD)) u_match (
        .alm_field(alm_field), .now_field(now_field), .rpt(rpt), .hit(hit)
    );

    cal_alarm_flag u_flag (
        .clk(clk), .rst_n(rst_n), .tick(sec_tick), .hit(hit),
        .afe(afe), .abe(abe), .backup(on_battery), .flag_rd(flag_rd),
        .af(af), .irq_pend(irq_pend), .irq_n_oe(irq_n_oe)
    );
endmodule

// File: rtl/cal_alarm_chk.sv
// Property checker for the calendar alarm, bound into the top.
// Assumes flags reads are never issued in the strobe cycle.
module cal_alarm_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sec_tick,
    input logic       bus_rd,
    input logic [3:0] bus_addr,
    input logic       on_battery,
    input logic       af,
    input logic       irq_pend,
    input logic       irq_n_oe,
    input logic       afe,
    input logic       abe
);
    // R5: the flag rises only after a strobe
    a_r5_af_rises_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(af) |-> $past(sec_tick));

    // R8: first flags read releases the interrupt and keeps the flag
    a_r8_first_read_keeps_af: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd0 && irq_pend && !sec_tick) |=> (af && !irq_pend));

    // R8: a flags read with nothing pending clears the flag
    a_r8_read_clears_af: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && bus_addr == 4'd0 && !irq_pend && !sec_tick) |=> !af);

    // R6: the pin is driven only with the flag set and interrupts enabled
    a_r6_irq_needs_af: assert property (@(posedge clk) disable iff (!rst_n)
        irq_n_oe |-> (af && afe));

    // R9: in backup the pin needs the backup enable
    a_r9_backup_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_n_oe && on_battery) |-> abe);
endmodule

bind cal_alarm cal_alarm_chk i_chk (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .on_battery(on_battery), .af(af),
    .irq_pend(irq_pend), .irq_n_oe(irq_n_oe), .afe(afe), .abe(abe)
);

// File: tb/test_cal_alarm.sv
// Scoreboard bench: driver tasks queue expected values, a monitor at the
// falling edge pops and compares them.
module test_cal_alarm;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sec_tick = 1'b0;
    logic [6:0] cur_sec = '0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [5:0] cur_date = '0;
    logic [4:0] cur_mon = '0;
    logic       on_battery = 1'b0;
    logic [3:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq_n_oe;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    string      q_req[$];
    int         q_sel[$];
    logic [7:0] q_exp[$];

    localparam logic [6:0] AS  = 7'h30;
    localparam logic [6:0] AM  = 7'h15;
    localparam logic [5:0] AH  = 6'h08;
    localparam logic [5:0] AD  = 6'h12;
    localparam logic [4:0] AMO = 5'h06;

    always #10 clk = ~clk;

    cal_alarm i_cal_alarm (.*);

    // Monitor: compare every queued expectation at the falling edge
    always @(negedge clk) begin
        while (q_req.size() > 0) begin
            string      r;
            int         s;
            logic [7:0] e;
            logic [7:0] a;
            r = q_req.pop_front();
            s = q_sel.pop_front();
            e = q_exp.pop_front();
            a = (s == 0) ? {7'b0, irq_n_oe} : bus_rdata;
            n_chk++;
            if (a !== e) begin
                n_fail++;
                $display("FAIL %s: %s got %h expected %h", r,
                         (s == 0) ? "irq_n_oe" : "bus_rdata", a, e);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
        sec_tick = 1'b0;
        bus_wr   = 1'b0;
        bus_rd   = 1'b0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        step();
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    endtask

    task automatic rd_check(input logic [3:0] a, input logic [7:0] e, input string r);
        step();
        bus_addr = a; bus_rd = 1'b1;
        q_req.push_back(r); q_sel.push_back(1); q_exp.push_back(e);
    endtask

    task automatic irq_check(input logic e, input string r);
        step();
        q_req.push_back(r); q_sel.push_back(0); q_exp.push_back({7'b0, e});
    endtask

    task automatic set_now(input logic [6:0] s, input logic [6:0] m, input logic [5:0] h,
                           input logic [5:0] d, input logic [4:0] mo);
        step();
        cur_sec = s; cur_min = m; cur_hour = h; cur_date = d; cur_mon = mo;
    endtask

    // rp is the repeat code coarsest-first: rp[4]=coarsest, rp[0]=finest
    task automatic prog(input logic [5:0] d, input logic [4:0] rp,
                        input logic afe, input logic abe);
        wr(4'd2, {rp[0], AS});
        wr(4'd3, {rp[1], AM});
        wr(4'd4, {rp[2], 1'b0, AH});
        wr(4'd5, {rp[3], rp[4], d});
        wr(4'd6, {afe, abe, 1'b0, AMO});
    endtask

    task automatic pulse_tick();
        step();
        sec_tick = 1'b1;
    endtask

    // Strobe, then check pin and the two-step clearing through the flags byte
    task automatic fire(input logic e_af, input logic e_irq, input string r);
        pulse_tick();
        irq_check(e_irq, r);
        if (e_irq) begin
            rd_check(4'd0, 8'h40, r);
            irq_check(1'b0, r);
            rd_check(4'd0, 8'h40, r);
            rd_check(4'd0, 8'h00, r);
        end else if (e_af) begin
            rd_check(4'd0, 8'h40, r);
            rd_check(4'd0, 8'h00, r);
        end else begin
            rd_check(4'd0, 8'h00, r);
        end
    endtask

    task automatic do_reset();
        step();
        rst_n = 1'b0;
        step();
        step();
        rst_n = 1'b1;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R10: state after reset
        irq_check(1'b0, "R10");
        rd_check(4'd6, 8'h00, "R10");
        rd_check(4'd0, 8'h00, "R10");

        // R1: register readback and unmapped addresses
        wr(4'd2, 8'hA5); wr(4'd3, 8'h5A); wr(4'd4, 8'h3C);
        wr(4'd5, 8'hC3); wr(4'd6, 8'h7E);
        rd_check(4'd2, 8'hA5, "R1");
        rd_check(4'd3, 8'h5A, "R1");
        rd_check(4'd4, 8'h3C, "R1");
        rd_check(4'd5, 8'hC3, "R1");
        rd_check(4'd6, 8'h7E, "R1");
        rd_check(4'd7, 8'h00, "R1");
        rd_check(4'd1, 8'h00, "R1");

        // R2: enable and repeat bit positions in the bytes
        prog(AD, 5'b10000, 1'b1, 1'b1);
        rd_check(4'd6, 8'hC6, "R2");
        rd_check(4'd5, 8'h52, "R2");
        rd_check(4'd2, 8'h30, "R2");

        // R3/R6: year mode
        prog(AD, 5'b00000, 1'b1, 1'b0);
        set_now(AS, AM, AH, AD, AMO);
        fire(1'b1, 1'b1, "R3_R6");
        set_now(AS, AM, AH, AD, 5'h07);
        fire(1'b0, 1'b0, "R3");
        // month mode
        prog(AD, 5'b10000, 1'b1, 1'b0);
        fire(1'b1, 1'b1, "R3");
        set_now(AS, AM, AH, 6'h13, 5'h07);
        fire(1'b0, 1'b0, "R3");
        // day mode
        prog(AD, 5'b11000, 1'b1, 1'b0);
        fire(1'b1, 1'b1, "R3");
        set_now(AS, AM, 6'h09, 6'h13, 5'h07);
        fire(1'b0, 1'b0, "R3");
        // hour mode
        prog(AD, 5'b11100, 1'b1, 1'b0);
        fire(1'b1, 1'b1, "R3");
        set_now(AS, 7'h16, 6'h09, 6'h13, 5'h07);
        fire(1'b0, 1'b0, "R3");
        // minute mode
        prog(AD, 5'b11110, 1'b1, 1'b0);
        fire(1'b1, 1'b1, "R3");
        set_now(7'h31, 7'h16, 6'h09, 6'h13, 5'h07);
        fire(1'b0, 1'b0, "R3");
        // second mode
        prog(AD, 5'b11111, 1'b1, 1'b0);
        fire(1'b1, 1'b1, "R3");

        // R4/R7: invalid codes fall back to every second; no pin without enable
        prog(AD, 5'b10101, 1'b0, 1'b0);
        fire(1'b1, 1'b0, "R4");
        prog(AD, 5'b01111, 1'b0, 1'b0);
        fire(1'b1, 1'b0, "R4");

        // R7: full match with the interrupt disabled
        prog(AD, 5'b00000, 1'b0, 1'b0);
        set_now(AS, AM, AH, AD, AMO);
        fire(1'b1, 1'b0, "R7");

        // R5: a match without a strobe does nothing
        prog(AD, 5'b00000, 1'b1, 1'b0);
        repeat (5) step();
        irq_check(1'b0, "R5");
        rd_check(4'd0, 8'h00, "R5");
        // R5: a spare bit in the hour byte is ignored by the compare
        wr(4'd4, 8'h48);
        rd_check(4'd4, 8'h48, "R1");
        fire(1'b1, 1'b1, "R5");

        // R9: backup mode gating
        on_battery = 1'b1;
        prog(AD, 5'b00000, 1'b1, 1'b0);
        fire(1'b1, 1'b0, "R9");
        prog(AD, 5'b00000, 1'b1, 1'b1);
        fire(1'b1, 1'b1, "R9");
        on_battery = 1'b0;

        // R11: zero alarm date with finest four repeat bits clear
        set_now(AS, AM, AH, AD, AMO);
        prog(6'h00, 5'b00000, 1'b1, 1'b0);
        fire(1'b0, 1'b0, "R11");
        prog(6'h00, 5'b10000, 1'b1, 1'b0);
        fire(1'b0, 1'b0, "R11");

        // R10: reset in the middle of a pending alarm
        prog(AD, 5'b00000, 1'b1, 1'b0);
        pulse_tick();
        irq_check(1'b1, "R6");
        do_reset();
        irq_check(1'b0, "R10");
        rd_check(4'd0, 8'h00, "R10");
        rd_check(4'd2, 8'h00, "R10");
        rd_check(4'd6, 8'h00, "R10");

        step();
        step();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule